// File: doc/BRIEF.md
# IR Edge Interval Timer

This block timestamps the edges of a demodulated infrared receiver line so that software can decode the remote-control protocol itself. The line is brought into the clock domain and cleaned of short glitches. A programmable prescaler divides a reference strobe into timing ticks, and a saturating counter measures how many ticks have passed since the most recent clean edge. The receiver line idles high, and a low level means that carrier is present.

On each edge picked by the interrupt-source select, the block stores the tick count of the interval that just ended, together with a flag telling whether that interval was carrier (pulse) or silence (space), and raises a one-cycle interrupt. Only the latest interval is kept. A software handler reads the value and the flag before the next selected edge arrives. For raw decoding, the select is set to interrupt on both edges, the divider to 9 (ten reference strobes per tick) and the filter length to 7.

Top module: `ir_edge_timer`

## Requirements
- R1: After reset, or one cycle after `cfg_clr_i` is high on a clock edge, `irq_o`, `interval_o` and `pulse_o` are all 0 and the conditioned line returns to its idle-high state.
- R2: One tick is produced for every `cfg_base_i`+1 reference strobes. The prescaler and the interval counter both restart at every clean edge, whether or not that edge is selected. The captured value for an edge that follows the previous clean edge by N clock cycles, with the strobe high on every cycle, is floor((N-1)/(`cfg_base_i`+1)).
- R3: The interval counter stops at 8191 and does not wrap. A span that is longer than 8191 ticks is reported as 8191.
- R4: With `cfg_irq_sel_i` = 1, both rising and falling clean edges capture an interval and raise `irq_o`.
- R5: With `cfg_irq_sel_i` = 2, only falling edges capture. With `cfg_irq_sel_i` = 3, only rising edges capture. The stored interval is measured from the edge immediately before, even when that edge was not selected.
- R6: With `cfg_irq_sel_i` = 0 (the code reserved for a protocol decoder), no edge captures and `irq_o` stays low.
- R7: `pulse_o` is 1 when the interval that ended was low (carrier), which means it was captured on a rising edge. It is 0 when the interval was high (space), captured on a falling edge.
- R8: While `cfg_enable_i` is low, no capture and no interrupt take place, and the counter is held at zero. When capture resumes, it behaves normally.
- R9: A line change must stay stable for `cfg_filt_i`+1 clock cycles after the two-stage synchroniser before it is accepted. A shorter glitch produces no interrupt and does not restart the counter.
- R10: `interval_o` and `pulse_o` change on the same clock edge on which `irq_o` rises, and they keep their values until the next selected edge.
- R11: When no reference strobes arrive, the counter does not advance and the captured interval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_enable_i | input | 1 | Capture enable |
| cfg_clr_i | input | 1 | Synchronous clear of all state |
| cfg_irq_sel_i | input | 2 | Edge select: 0 decoder-only, 1 both, 2 falling, 3 rising |
| cfg_base_i | input | 12 | Prescaler divide value minus one |
| cfg_filt_i | input | 3 | Glitch filter length minus one, in clock cycles |
| ref_stb_i | input | 1 | Reference timebase strobe |
| ir_line_i | input | 1 | Asynchronous receiver line, idle high |
| irq_o | output | 1 | One-cycle capture interrupt |
| interval_o | output | 13 | Ticks in the interval that just ended |
| pulse_o | output | 1 | 1 if the ended interval was carrier (line low) |

## Verification
The embedded properties assume that the select, divider and filter settings do not change while an edge is making its way through the synchroniser and the filter. They also assume that the clear input is a plain synchronous strobe. The stimulus changes configuration only in the middle of segments that are much longer than that latency. After any change to the clear, the enable, the divider or the strobe, the stimulus first sends one edge with the select at 0. This way, every checked interval starts from a known clean edge. Every real line segment lasts longer than the filter window, and glitches are kept shorter than it, so the expected values follow directly from cycle counts.

// File: rtl/ir_edge_pkg.sv
package ir_edge_pkg;

    // Interrupt-source select codes; the values are decoded by the capture stage.
    typedef enum logic [1:0] {
        IRQ_DECODER = 2'd0,
        IRQ_BOTH    = 2'd1,
        IRQ_FALL    = 2'd2,
        IRQ_RISE    = 2'd3
    } irq_sel_e;

    // Receiver line level when no carrier is present.
    localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/ir_line_cond.sv
// Two-stage synchroniser, programmable glitch filter and edge strobes.
module ir_line_cond
    import ir_edge_pkg::*;
#(
    parameter int FILT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic              line_i,
    output logic              level_o,
    output logic              rise_o,
    output logic              fall_o
);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              lvl;
        logic [FILT_W-1:0] run;
    } cond_t;

    cond_t st_d, st_q;
    logic  flip;

    always_comb begin
        st_d = st_q;
        flip = 1'b0;
        if (clr_i) begin
            st_d.s1  = LINE_IDLE;
            st_d.s2  = LINE_IDLE;
            st_d.lvl = LINE_IDLE;
            st_d.run = '0;
        end else begin
            st_d.s1 = line_i;
            st_d.s2 = st_q.s1;
            if (st_q.s2 != st_q.lvl) begin
                if (st_q.run >= filt_len_i) begin
                    st_d.lvl = st_q.s2;
                    st_d.run = '0;
                    flip     = 1'b1;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.s1  <= LINE_IDLE;
            st_q.s2  <= LINE_IDLE;
            st_q.lvl <= LINE_IDLE;
            st_q.run <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
    assign rise_o  = flip &  st_q.s2;
    assign fall_o  = flip & ~st_q.s2;

    // The clean level only moves to a value the synchroniser already showed.
    assert_filter_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lvl != $past(st_q.lvl)) && !$past(clr_i) |-> (st_q.lvl == $past(st_q.s2)));

    assert_clear_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (st_q.lvl == LINE_IDLE) && (st_q.run == '0));

endmodule

// File: rtl/ir_tick_gen.sv
// Prescaler: one tick per (base+1) reference strobes, phase realigned on every edge.
module ir_tick_gen #(
    parameter int BASE_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic              ref_stb_i,
    input  logic [BASE_W-1:0] base_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [BASE_W-1:0] pre;
    } tick_t;

    tick_t st_d, st_q;
    logic  tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run_i || restart_i) begin
            st_d.pre = '0;
        end else if (ref_stb_i) begin
            if (st_q.pre >= base_i) begin
                st_d.pre = '0;
                tick     = 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pre <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick;

    // With a steady divider the phase counter never runs past it.
    assert_prescale_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(base_i) && ($past(st_q.pre) <= $past(base_i)) |-> (st_q.pre <= base_i));

endmodule

// File: rtl/ir_interval_cap.sv
// Saturating interval counter, edge selection and capture registers.
module ir_interval_cap
    import ir_edge_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [1:0]       sel_i,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             irq_o,
    output logic [CNT_W-1:0] interval_o,
    output logic             pulse_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ivl;
        logic             pulse;
        logic             irq;
    } cap_t;

    cap_t     st_d, st_q;
    irq_sel_e sel;
    logic     any_edge;
    logic     take;

    assign sel      = irq_sel_e'(sel_i);
    assign any_edge = rise_i | fall_i;

    always_comb begin
        unique case (sel)
            IRQ_BOTH: take = any_edge;
            IRQ_FALL: take = fall_i;
            IRQ_RISE: take = rise_i;
            default:  take = 1'b0;
        endcase
        take = take & en_i;
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (clr_i) begin
            st_d.cnt   = '0;
            st_d.ivl   = '0;
            st_d.pulse = 1'b0;
        end else begin
            if (!en_i || any_edge) begin
                st_d.cnt = '0;
            end else if (tick_i && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (take) begin
                st_d.ivl   = st_q.cnt;
                st_d.pulse = rise_i;
                st_d.irq   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.ivl   <= '0;
            st_q.pulse <= 1'b0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign interval_o = st_q.ivl;
    assign pulse_o    = st_q.pulse;

    assert_cnt_saturate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && !clr_i && !any_edge && (st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

    assert_cnt_monotone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && !clr_i && !any_edge |=> (st_q.cnt >= $past(st_q.cnt)));

    assert_decoder_sel_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ($past(sel_i) != 2'(IRQ_DECODER)));

    assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(en_i));

    assert_fall_is_space_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && ($past(sel_i) == 2'(IRQ_FALL)) |-> !pulse_o);

    assert_rise_is_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && ($past(sel_i) == 2'(IRQ_RISE)) |-> pulse_o);

    assert_capture_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o && !$past(clr_i) |-> ($stable(interval_o) && $stable(pulse_o)));

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
    parameter int CNT_W  = 13,
    parameter int BASE_W = 12,
    parameter int FILT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_enable_i,
    input  logic              cfg_clr_i,
    input  logic [1:0]        cfg_irq_sel_i,
    input  logic [BASE_W-1:0] cfg_base_i,
    input  logic [FILT_W-1:0] cfg_filt_i,
    input  logic              ref_stb_i,
    input  logic              ir_line_i,
    output logic              irq_o,
    output logic [CNT_W-1:0]  interval_o,
    output logic              pulse_o
);

    logic level;
    logic rise;
    logic fall;
    logic tick;
    logic run;

    assign run = cfg_enable_i & ~cfg_clr_i;

    ir_line_cond #(
        .FILT_W (FILT_W)
    ) u_line (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (cfg_clr_i),
        .filt_len_i (cfg_filt_i),
        .line_i     (ir_line_i),
        .level_o    (level),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    ir_tick_gen #(
        .BASE_W (BASE_W)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (rise | fall),
        .ref_stb_i (ref_stb_i),
        .base_i    (cfg_base_i),
        .tick_o    (tick)
    );

    ir_interval_cap #(
        .CNT_W (CNT_W)
    ) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (cfg_enable_i),
        .clr_i      (cfg_clr_i),
        .sel_i      (cfg_irq_sel_i),
        .tick_i     (tick),
        .rise_i     (rise),
        .fall_i     (fall),
        .irq_o      (irq_o),
        .interval_o (interval_o),
        .pulse_o    (pulse_o)
    );

    // A clean edge always moves the conditioned level in its own direction.
    assert_edge_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise || fall) && !cfg_clr_i |=> (level == $past(rise)));

endmodule

// File: tb/ir_edge_timer_bench.sv
module ir_edge_timer_bench;

    localparam int SAT = 8191;

    typedef struct {
        int    ivl;
        bit    lvl;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic        clr = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic [11:0] base = 12'd9;
    logic [2:0]  filt = 3'd7;
    logic        ref_stb = 1'b1;
    logic        line = 1'b1;
    logic        irq;
    logic [12:0] ivl;
    logic        pulse;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    int   last_ivl = 0;
    bit   cur = 1'b1;
    int   span = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    ir_edge_timer u_ir_edge_timer (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cfg_enable_i  (en),
        .cfg_clr_i     (clr),
        .cfg_irq_sel_i (sel),
        .cfg_base_i    (base),
        .cfg_filt_i    (filt),
        .ref_stb_i     (ref_stb),
        .ir_line_i     (line),
        .irq_o         (irq),
        .interval_o    (ivl),
        .pulse_o       (pulse)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: moves the line and predicts the capture of the interval it closes.
    task automatic drive(bit lvl, int n, string tag);
        exp_t e;
        if (lvl != cur) begin
            if (en && (sel == 2'd1 || (sel == 2'd2 && !lvl) || (sel == 2'd3 && lvl))) begin
                e.ivl = ref_stb ? (span - 1) / (int'(base) + 1) : 0;
                if (e.ivl > SAT) e.ivl = SAT;
                e.lvl = lvl;
                e.tag = tag;
                q.push_back(e);
            end
            cur  = lvl;
            line = lvl;
            span = 0;
        end
        repeat (n) @(negedge clk);
        span += n;
    endtask

    task automatic glitch(int g);
        line = ~cur;
        repeat (g) @(negedge clk);
        line = cur;
        span += g;
    endtask

    // One unchecked edge so that the next interval starts at a known clean edge.
    task automatic warmup(logic [1:0] next_sel);
        sel = 2'd0;
        drive(~cur, 40, "");
        sel = next_sel;
    endtask

    // Monitor: pops the scoreboard on every interrupt.
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R4/R6/R8 unexpected irq actual interval %0d expected no irq", ivl);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "interval", int'(ivl), e.ivl);
                check(e.tag, "pulse flag", int'(pulse), int'(e.lvl));
                last_ivl = e.ivl;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: state out of reset
        check("R1", "irq at reset", int'(irq), 0);
        check("R1", "interval at reset", int'(ivl), 0);
        check("R1", "pulse at reset", int'(pulse), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Both edges: R2 R4 R7
        warmup(2'd1);
        drive(1'b1, 200, "R4");
        drive(1'b0, 123, "R2");
        drive(1'b1, 57, "R7");
        drive(1'b0, 10, "R2");
        drive(1'b1, 11, "R2");
        drive(1'b0, 60, "R2");

        // Falling only: R5, hold R10
        sel = 2'd2;
        drive(1'b1, 80, "R5");
        drive(1'b0, 90, "R5");
        drive(1'b1, 50, "R5");
        check("R10", "held interval", int'(ivl), last_ivl);
        drive(1'b0, 40, "R5");

        // Rising only: R5 R7
        sel = 2'd3;
        drive(1'b1, 70, "R5");
        drive(1'b0, 30, "R5");
        check("R10", "held interval", int'(ivl), last_ivl);
        drive(1'b1, 40, "R7");

        // Decoder code selects nothing: R6
        sel = 2'd0;
        drive(1'b0, 40, "R6");
        drive(1'b1, 40, "R6");
        check("R6", "interval unchanged", int'(ivl), last_ivl);

        // Glitch shorter than the filter window: R9
        sel = 2'd1;
        drive(1'b0, 50, "R9");
        glitch(4);
        drive(1'b0, 50, "R9");
        drive(1'b1, 40, "R9");

        // No reference strobes: R11
        sel = 2'd0;
        ref_stb = 1'b0;
        warmup(2'd1);
        drive(~cur, 100, "R11");
        sel = 2'd0;
        ref_stb = 1'b1;
        warmup(2'd1);

        // Saturation with a divide of one: R3
        sel = 2'd0;
        base = 12'd0;
        warmup(2'd1);
        drive(~cur, 9000, "R2");
        drive(~cur, 8192, "R3");
        drive(~cur, 8000, "R3");
        drive(~cur, 40, "R3");
        sel = 2'd0;
        base = 12'd9;
        warmup(2'd1);

        // Disabled: R8
        en = 1'b0;
        drive(~cur, 50, "R8");
        drive(~cur, 50, "R8");
        check("R8", "interval held while disabled", int'(ivl), last_ivl);
        en = 1'b1;
        warmup(2'd1);
        drive(~cur, 60, "R8");

        // Synchronous clear: R1
        if (cur != 1'b1) drive(1'b1, 40, "R1");
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R1", "irq after clear", int'(irq), 0);
        check("R1", "interval after clear", int'(ivl), 0);
        check("R1", "pulse after clear", int'(pulse), 0);
        warmup(2'd0);
        repeat (50) @(negedge clk);

        check("R4", "pending expected captures", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule